// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five requester levels (0 to 4) owns a shared register interface at any time. Each level has an 8-bit access register. Software running at a level writes an access byte to ask for ownership, give it up, take it by force, or acknowledge that it was displaced. The block reports the owning level, or 0xFF when no level owns the interface. It also returns the access register of any level for reading, and raises a one-cycle event toward interrupt logic whenever the owner changes.

A plain request is queued while some other level owns the interface. When the owner releases, the highest-numbered requester takes over. A level numerically above the owner may seize ownership outright. The displaced owner is then left with a sticky flag that it must clear itself.

Every change of owner is a hand-off, and a hand-off must not cut off work that is still running. If any level reports work in flight, the block pulses an abort request and keeps the current owner until a cancel-complete indication arrives. If no work is in flight, the hand-off takes effect in the same clock edge as the write.

Top module: `loc_arbiter`

## Requirements
- R1: After reset the owner output reads 0xFF, every level's access register reads 0x80 (only bit 7, valid-status, set), and the abort and change pulses are low.
- R2: A write with bit 1 (request-use) from a level that is not the owner makes that level the owner at the next clock edge if no level owns the interface; otherwise it sets that level's bit 1.
- R3: When the owner writes bit 5 (active), it releases ownership. The new owner is the highest-numbered level with bit 1 set, or 0xFF if none is set. The old owner ends with bits 5 and 1 clear.
- R4: When a level that is not the owner writes bit 5, its own bit 1 is cleared and the owner is unchanged.
- R5: A write with bit 3 (seize) is honoured only if no level owns the interface or the writer's number is above the owner's. It is ignored if the writer already has a seize pending or any higher level does. Honouring it cancels the pending seizes of all lower levels.
- R6: When ownership moves because of a seize, the old owner loses bit 5 and gains bit 4 (been-seized).
- R7: The new owner reads bit 5 set and bits 1 and 3 clear. The change output pulses high for exactly one cycle, and only when the owner actually changes.
- R8: Bit 3 always reads 0. Bit 2 (pending-request) reads 1 exactly when some other level has bit 1 set.
- R9: Writing a 1 to bit 4 clears that level's been-seized flag.
- R10: Writes addressed to level 4, or to a level number above 4, change no state.
- R11: If any busy input is high when a hand-off is decided, the abort output pulses for one cycle and the owner stays the same until cancel_done. Once cancel_done arrives, the hand-off completes at the next edge. A cancel_done with nothing pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Access-byte write strobe |
| wr_lvl | input | 3 | Level addressed by the write |
| wr_data | input | 8 | Access byte written |
| rd_lvl | input | 3 | Level whose access register is read |
| rd_data | output | 8 | Read value of that level's access register |
| busy | input | 5 | Per-level work-in-flight flags |
| cancel_done | input | 1 | In-flight work has been cancelled |
| active_lvl | output | 8 | Owning level, 0xFF for none |
| abort_req | output | 1 | One-cycle request to abort in-flight work |
| loc_chg | output | 1 | One-cycle owner-changed event |

## Verification
The core arbitration is driven through one long write sequence. The sequence mixes queued requests from several levels, a release with two requesters waiting, a release with none waiting, a seize from below the owner, a seize with no owner, and a seize from above. Together these separate the highest-requester choice from a first-requester choice, separate a seize hand-off from a release hand-off by the old owner's flags, and show whether the change event follows real owner changes only. Directed runs with busy high show that the hand-off really waits for cancel_done. They also show that a seize below a pending higher seize is dropped, and that a seize written to the read-only level starts no abort.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
   localparam int ACT_W     = 8;
   localparam logic [ACT_W-1:0] NONE_LVL = 8'hFF;
   localparam int B_VALID   = 7;
   localparam int B_ACT     = 5;
   localparam int B_BSZ     = 4;
   localparam int B_SZ      = 3;
   localparam int B_PEND    = 2;
   localparam int B_REQ     = 1;
   localparam logic [7:0] ACC_RST = 8'h80;
endpackage

// File: rtl/loc_read_port.sv
module loc_read_port
   import loc_arb_pkg::*;
#(
   parameter int NUM_LVL = 5,
   parameter int LVL_W   = 3
) (
   input  logic [NUM_LVL-1:0][7:0] acc,
   input  logic [LVL_W-1:0]        rd_lvl,
   output logic [7:0]              rd_data
);
   logic [NUM_LVL-1:0] req_bits;
   logic [NUM_LVL-1:0] other_req;
   logic [NUM_LVL-1:0][7:0] shown;

   genvar g;
   generate
      for (g = 0; g < NUM_LVL; g++) begin : g_lvl
         assign req_bits[g] = acc[g][B_REQ];
         assign other_req[g] = |(req_bits & ~(NUM_LVL'(1) << g));
         always_comb begin
            shown[g] = acc[g];
            shown[g][B_SZ] = 1'b0;
            shown[g][B_PEND] = other_req[g];
         end
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (int'(rd_lvl) == i) rd_data = shown[i];
      end
   end
endmodule

// File: rtl/loc_abort_seq.sv
module loc_abort_seq
   import loc_arb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ho_req,
   input  logic [ACT_W-1:0] ho_next,
   input  logic             busy_any,
   input  logic             cancel_done,
   output logic             fin,
   output logic [ACT_W-1:0] fin_next,
   output logic             abort_req
);
   logic             pend_q;
   logic [ACT_W-1:0] next_q;
   logic             abort_q;

   assign fin       = pend_q && cancel_done;
   assign fin_next  = next_q;
   assign abort_req = abort_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         next_q  <= NONE_LVL;
         abort_q <= 1'b0;
      end else begin
         abort_q <= ho_req && busy_any;
         if (ho_req) begin
            pend_q <= busy_any;
            next_q <= busy_any ? ho_next : NONE_LVL;
         end else if (fin) begin
            pend_q <= 1'b0;
            next_q <= NONE_LVL;
         end
      end
   end

   AST_ABORT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> pend_q); // R11
   AST_NEXT_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q == (next_q != NONE_LVL)); // R11
endmodule

// File: rtl/loc_own_core.sv
module loc_own_core
   import loc_arb_pkg::*;
#(
   parameter int NUM_LVL = 5,
   parameter int LVL_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_ok,
   input  logic [LVL_W-1:0]        wr_lvl,
   input  logic [7:0]              wr_data,
   input  logic                    busy_any,
   input  logic                    fin,
   input  logic [ACT_W-1:0]        fin_next,
   output logic                    ho_req,
   output logic [ACT_W-1:0]        ho_next,
   output logic [NUM_LVL-1:0][7:0] acc_q,
   output logic [ACT_W-1:0]        act_q,
   output logic                    chg_q
);
   typedef struct packed {
      logic [NUM_LVL-1:0][7:0] acc;
      logic [ACT_W-1:0]        act;
   } own_t;

   function automatic own_t f_newown(own_t si, logic [ACT_W-1:0] nl);
      own_t so;
      logic by_seize;
      so = si;
      by_seize = 1'b0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (ACT_W'(i) == nl && si.acc[i][B_SZ]) by_seize = 1'b1;
      end
      if (si.act != nl) begin
         for (int i = 0; i < NUM_LVL; i++) begin
            if (ACT_W'(i) == si.act) begin
               so.acc[i][B_ACT] = 1'b0;
               if (by_seize) so.acc[i][B_BSZ] = 1'b1;
               else          so.acc[i][B_REQ] = 1'b0;
            end
         end
      end
      so.act = nl;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (ACT_W'(i) == nl) begin
            so.acc[i][B_ACT] = 1'b1;
            so.acc[i][B_REQ] = 1'b0;
            so.acc[i][B_SZ]  = 1'b0;
         end
      end
      return so;
   endfunction

   own_t             s;
   logic [7:0]       v;
   logic [ACT_W-1:0] lvl8;
   logic [ACT_W-1:0] tgt;
   logic [ACT_W-1:0] top;
   logic             keep;
   logic             any_req;
   logic             hi_sz;

   assign lvl8 = ACT_W'(wr_lvl);

   always_comb begin
      s.acc   = acc_q;
      s.act   = act_q;
      ho_req  = 1'b0;
      ho_next = NONE_LVL;
      keep    = 1'b1;
      any_req = 1'b0;
      top     = NONE_LVL;
      hi_sz   = 1'b0;
      v       = 8'h00;
      if (fin) s = f_newown(s, fin_next);
      tgt = s.act;
      if (wr_ok) begin
         v = wr_data;
         if (v[B_SZ]) begin
            v[B_REQ] = 1'b0;
            v[B_ACT] = 1'b0;
         end
         // release or withdraw
         if (v[B_ACT]) begin
            if (s.act == lvl8) begin
               for (int i = NUM_LVL - 1; i >= 0; i--) begin
                  if (!any_req && s.acc[i][B_REQ]) begin
                     any_req = 1'b1;
                     top     = ACT_W'(i);
                  end
               end
               if (any_req) begin
                  keep    = 1'b0;
                  ho_req  = 1'b1;
                  ho_next = top;
                  if (!busy_any) s = f_newown(s, top);
               end else begin
                  tgt = NONE_LVL;
               end
            end else begin
               for (int i = 0; i < NUM_LVL; i++)
                  if (i == int'(wr_lvl)) s.acc[i][B_REQ] = 1'b0;
            end
         end
         // acknowledge displacement
         if (v[B_BSZ]) begin
            for (int i = 0; i < NUM_LVL; i++)
               if (i == int'(wr_lvl)) s.acc[i][B_BSZ] = 1'b0;
         end
         // forced take-over
         if (v[B_SZ]) begin
            for (int i = 0; i < NUM_LVL; i++) begin
               if (i > int'(wr_lvl) && s.acc[i][B_SZ]) hi_sz = 1'b1;
               if (i == int'(wr_lvl) && s.acc[i][B_SZ]) hi_sz = 1'b1;
            end
            if ((s.act == NONE_LVL || lvl8 > s.act) && !hi_sz) begin
               for (int i = 0; i < NUM_LVL; i++) begin
                  if (i < int'(wr_lvl))  s.acc[i][B_SZ] = 1'b0;
                  if (i == int'(wr_lvl)) s.acc[i][B_SZ] = 1'b1;
               end
               keep    = 1'b0;
               ho_req  = 1'b1;
               ho_next = lvl8;
               if (!busy_any) s = f_newown(s, lvl8);
            end
         end
         // queued or direct request
         if (v[B_REQ] && s.act != lvl8) begin
            if (s.act != NONE_LVL) begin
               for (int i = 0; i < NUM_LVL; i++)
                  if (i == int'(wr_lvl)) s.acc[i][B_REQ] = 1'b1;
            end else begin
               tgt = lvl8;
            end
         end
         if (keep) s = f_newown(s, tgt);
      end
   end

   logic unused_bits;
   assign unused_bits = ^{v[7:6], v[2], v[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LVL; i++) acc_q[i] <= ACC_RST;
         act_q <= NONE_LVL;
         chg_q <= 1'b0;
      end else begin
         acc_q <= s.acc;
         act_q <= s.act;
         chg_q <= (s.act != act_q);
      end
   end

   logic [NUM_LVL-1:0] act_bits;
   logic [NUM_LVL-1:0] sz_bits;
   logic               owner_flag;
   always_comb begin
      owner_flag = 1'b0;
      for (int i = 0; i < NUM_LVL; i++) begin
         act_bits[i] = acc_q[i][B_ACT];
         sz_bits[i]  = acc_q[i][B_SZ];
         if (ACT_W'(i) == act_q) owner_flag = acc_q[i][B_ACT];
      end
   end

   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_bits) && ((act_q == NONE_LVL) ? (act_bits == '0) : owner_flag)); // R7
   AST_SEIZE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sz_bits)); // R5
   AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      act_q == NONE_LVL || act_q < ACT_W'(NUM_LVL)); // R3
   AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> $past(wr_ok || fin)); // R7
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
   import loc_arb_pkg::*;
#(
   parameter int NUM_LVL = 5,
   parameter bit RO_EN   = 1'b1,
   parameter int RO_LVL  = NUM_LVL - 1,
   localparam int LVL_W  = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LVL_W-1:0]   wr_lvl,
   input  logic [7:0]         wr_data,
   input  logic [LVL_W-1:0]   rd_lvl,
   output logic [7:0]         rd_data,
   input  logic [NUM_LVL-1:0] busy,
   input  logic               cancel_done,
   output logic [ACT_W-1:0]   active_lvl,
   output logic               abort_req,
   output logic               loc_chg
);
   generate
      if (NUM_LVL < 2 || NUM_LVL > 8) begin : g_bad_num
         $error("loc_arbiter: NUM_LVL must lie in 2..8");
      end
      if (RO_LVL < 0 || RO_LVL >= NUM_LVL) begin : g_bad_ro
         $error("loc_arbiter: RO_LVL out of range");
      end
   endgenerate

   logic                    wr_ok;
   logic                    in_range;
   logic                    busy_any;
   logic                    ho_req;
   logic [ACT_W-1:0]        ho_next;
   logic                    fin;
   logic [ACT_W-1:0]        fin_next;
   logic [NUM_LVL-1:0][7:0] acc_q;
   logic [ACT_W-1:0]        act_q;

   assign busy_any = |busy;
   assign in_range = int'(wr_lvl) < NUM_LVL;

   generate
      if (RO_EN) begin : g_ro
         assign wr_ok = wr_en && in_range && (int'(wr_lvl) != RO_LVL);
      end else begin : g_rw
         assign wr_ok = wr_en && in_range;
      end
   endgenerate

   loc_own_core #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_ok),
      .wr_lvl   (wr_lvl),
      .wr_data  (wr_data),
      .busy_any (busy_any),
      .fin      (fin),
      .fin_next (fin_next),
      .ho_req   (ho_req),
      .ho_next  (ho_next),
      .acc_q    (acc_q),
      .act_q    (act_q),
      .chg_q    (loc_chg)
   );

   loc_abort_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ho_req      (ho_req),
      .ho_next     (ho_next),
      .busy_any    (busy_any),
      .cancel_done (cancel_done),
      .fin         (fin),
      .fin_next    (fin_next),
      .abort_req   (abort_req)
   );

   loc_read_port #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_rd (
      .acc     (acc_q),
      .rd_lvl  (rd_lvl),
      .rd_data (rd_data)
   );

   assign active_lvl = act_q;

   AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (RO_EN && wr_en && int'(wr_lvl) == RO_LVL && !fin) |=> ($stable(acc_q) && $stable(act_q))); // R10
endmodule

// File: tb/loc_arbiter_test.sv
module loc_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_lvl = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [2:0] rd_lvl = 3'd0;
   logic [4:0] busy = 5'd0;
   logic       cancel_done = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] active_lvl;
   logic       abort_req;
   logic       loc_chg;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   loc_arbiter uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_data(wr_data),
      .rd_lvl(rd_lvl), .rd_data(rd_data), .busy(busy), .cancel_done(cancel_done),
      .active_lvl(active_lvl), .abort_req(abort_req), .loc_chg(loc_chg)
   );

   // fields: level, data, read level, expected owner, expected read value
   localparam logic [39:0] VEC [0:12] = '{
      40'h00_02_00_00_A0,  // R2 direct request with no owner
      40'h02_02_00_00_A4,  // R2 queued request, R8 pending on owner
      40'h01_02_00_00_A4,  // R2
      40'h00_20_00_02_84,  // R3 highest requester wins
      40'h01_20_01_02_80,  // R4 withdraw request
      40'h03_08_02_03_90,  // R6 seize from above
      40'h02_10_02_03_80,  // R9 clear been-seized
      40'h01_08_01_03_80,  // R5 seize from below ignored, R8 seize reads 0
      40'h04_02_04_03_80,  // R10 level 4 write ignored
      40'h03_20_03_FF_80,  // R3 release with no requester
      40'h02_08_02_02_A0,  // R5 seize with no owner
      40'h00_02_02_02_A4,  // R8 pending seen by owner
      40'h03_08_02_03_94   // R6 seized owner flags
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] lvl, input logic [7:0] data);
      @(negedge clk);
      wr_lvl  = lvl;
      wr_data = data;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] lvl, input logic [7:0] exp, input string tag);
      rd_lvl = lvl;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic done_pulse();
      @(negedge clk);
      cancel_done = 1'b1;
      @(negedge clk);
      cancel_done = 1'b0;
   endtask

   task automatic reset_check(input string tag);
      chk(tag, active_lvl, 8'hFF);
      chk(tag, {6'd0, abort_req, loc_chg}, 8'h00);
      for (int i = 0; i < 5; i++) rd_chk(3'(i), 8'h80, tag);
   endtask

   initial begin
      #(20 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_check("R1 reset state");

      prev = 8'hFF;
      for (int k = 0; k < 13; k++) begin
         wr(VEC[k][34:32], VEC[k][31:24]);
         chk($sformatf("R2/R3/R5 row %0d owner", k), active_lvl, VEC[k][15:8]);
         chk($sformatf("R7 row %0d change pulse", k), {7'd0, loc_chg},
             {7'd0, VEC[k][15:8] != prev});
         chk($sformatf("R11 row %0d no abort when idle", k), {7'd0, abort_req}, 8'h00);
         rd_chk(VEC[k][18:16], VEC[k][7:0], $sformatf("R8 row %0d read", k));
         prev = VEC[k][15:8];
      end
      @(negedge clk);
      chk("R7 pulse lasts one cycle", {7'd0, loc_chg}, 8'h00);

      // R11 deferred release: owner 3, level 0 waiting
      busy = 5'b00001;
      wr(3'd3, 8'h20);
      chk("R11 owner held while busy", active_lvl, 8'h03);
      chk("R11 abort pulse", {7'd0, abort_req}, 8'h01);
      @(negedge clk);
      chk("R11 abort is one cycle", {7'd0, abort_req}, 8'h00);
      chk("R11 still waiting", active_lvl, 8'h03);
      done_pulse();
      chk("R11 hand-off after cancel", active_lvl, 8'h00);
      chk("R7 change after deferred hand-off", {7'd0, loc_chg}, 8'h01);
      rd_chk(3'd3, 8'h80, "R3 old owner flags after release");

      // R5 lower seize dropped while a higher one is pending
      wr(3'd2, 8'h08);
      chk("R5 seize deferred", active_lvl, 8'h00);
      chk("R5 seize abort", {7'd0, abort_req}, 8'h01);
      wr(3'd1, 8'h08);
      chk("R5 lower seize starts no abort", {7'd0, abort_req}, 8'h00);
      done_pulse();
      chk("R5 pending higher seize wins", active_lvl, 8'h02);
      rd_chk(3'd0, 8'h90, "R6 been-seized on old owner");
      rd_chk(3'd1, 8'h80, "R5 lower seizer unaffected");

      // R10 seize written to level 4 and to a missing level
      wr(3'd4, 8'h08);
      chk("R10 level 4 seize ignored", active_lvl, 8'h02);
      chk("R10 level 4 no abort", {7'd0, abort_req}, 8'h00);
      wr(3'd6, 8'h08);
      chk("R10 out-of-range ignored", active_lvl, 8'h02);
      chk("R10 out-of-range no abort", {7'd0, abort_req}, 8'h00);

      // R11 stray cancel_done
      busy = 5'b00000;
      done_pulse();
      chk("R11 stray cancel ignored", active_lvl, 8'h02);

      // R1 reset in mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_check("R1 reset after use");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule